// File: doc/BRIEF.md
# Four-State Address Pin Decoder

This block works out what each of two address-select pins is wired to. A pin may be tied to ground, to supply, to the I2C data line or to the I2C clock line. The block watches each pin against the live SDA and SCL lines during a bus transmission and gives every pin one of four 2-bit codes. The codes are applied when the transmission ends, and they are worked out again on every later transmission, so the board can change the wiring while running. A transmission is decoded whether or not it is addressed to this device.

The two codes form the low bits of the slave address. The same pair of codes indexes a small registered lookup that gives a pullup enable for each group of four ports, across 16 ports. Ports with a pullup enabled default to a high level and the other ports default to low. Until the first transmission has been decoded, a pin wired to a bus line looks like a fixed level, and the outputs follow that provisional reading.

Top module: `addr_pin_decoder`

## Requirements
- R1: While `rst` is high, `decode_valid` is 0, `pin_code` is 0, and `pullup_en` and `default_lvl` are all zeros.
- R2: Before the first decode, each pin's code is {0, pin level} one cycle after the pin is sampled.
- R3: A pin that equalled SCL at every sample of a transmission, in which SCL was seen both low and high, is coded 2'b10.
- R4: A pin that does not meet R3 and that equalled SDA at every sample, in which SDA was seen both low and high, is coded 2'b11.
- R5: Any other pin is coded by the level it held at the stop strobe: 2'b00 for low (ground) and 2'b01 for high (supply). A pin wired to SCL in a transmission with no clock toggles is therefore coded 2'b01. A sample is any cycle strictly between the start strobe and the stop strobe.
- R6: On the clock edge that takes a `bus_stop` after a `bus_start`, the codes update and `decode_valid` goes to 1. It then stays at 1 until reset.
- R7: Once `decode_valid` is 1, the codes hold between stop strobes whatever the pins do.
- R8: A `bus_stop` with no open transmission changes nothing.
- R9: Every new transmission replaces the previous codes.
- R10: `slave_addr` = {ADDR_BASE (3 bits, default 3'b101), code of pin 1, code of pin 0}.
- R11: One cycle after the codes change, `pullup_en` follows them. Pin 0 controls ports 0-7 and pin 1 controls ports 8-15, as follows: ground turns both of its groups of four off, supply turns both on, SCL turns on only the lower group, and SDA turns on only the upper group.
- R12: `default_lvl` equals `pullup_en` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_pin | input | NUM_PINS | Synchronized address-select pins, bit 0 is pin 0 |
| sda | input | 1 | Synchronized I2C data line |
| scl | input | 1 | Synchronized I2C clock line |
| bus_start | input | 1 | One-cycle START condition strobe |
| bus_stop | input | 1 | One-cycle STOP condition strobe |
| pin_code | output | 2*NUM_PINS | 2-bit code per pin, pin 0 in bits 1:0 |
| decode_valid | output | 1 | A full decode has completed |
| slave_addr | output | ADDR_W | Derived slave address |
| pullup_en | output | 4*NUM_PINS*GROUP_SIZE/2 | Per-port pullup enable (16 by default) |
| default_lvl | output | 4*NUM_PINS*GROUP_SIZE/2 | Per-port power-up level (16 by default) |

## Verification
The hardest case to reach is the ambiguous one: a pin wired to SCL during a transmission in which the clock never toggles. Such a pin must fall back to a static-high code and not be taken as SCL. The bench produces this case with a start strobe followed directly by a stop strobe, with both bus lines idle high. It then runs real byte transfers that contain mixed data bits, so that a pin following SDA and a pin following SCL each diverge from the other line at least once. Stop strobes with no open transmission, and pin rewiring between transmissions, are sent while a decode is held.

// File: rtl/apd_pkg.sv
package apd_pkg;

  typedef enum logic [1:0] {
    PIN_GND = 2'b00,
    PIN_VDD = 2'b01,
    PIN_SCL = 2'b10,
    PIN_SDA = 2'b11
  } pin_state_e;

  // Group-enable pair for one pin: bit 0 = lower group, bit 1 = upper group.
  function automatic logic [1:0] group_bits(input pin_state_e st);
    case (st)
      PIN_GND: group_bits = 2'b00;
      PIN_VDD: group_bits = 2'b11;
      PIN_SCL: group_bits = 2'b01;
      default: group_bits = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/apd_xfer_tracker.sv
module apd_xfer_tracker (
  input  logic clk,
  input  logic rst,
  input  logic bus_start,
  input  logic bus_stop,
  output logic acc_clear,
  output logic acc_sample,
  output logic latch_now,
  output logic decode_valid
);

  logic open_q;
  logic valid_q;

  assign acc_clear    = bus_start;
  assign acc_sample   = open_q & ~bus_start & ~bus_stop;
  assign latch_now    = open_q & bus_stop;
  assign decode_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (bus_start)
        open_q <= 1'b1;
      else if (bus_stop)
        open_q <= 1'b0;
      if (latch_now)
        valid_q <= 1'b1;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q); // R6

  AST_VALID_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(bus_stop)); // R6

endmodule

// File: rtl/apd_pin_classifier.sv
module apd_pin_classifier
  import apd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       sda,
  input  logic       scl,
  input  logic       acc_clear,
  input  logic       acc_sample,
  input  logic       latch_now,
  input  logic       decode_valid,
  output logic [1:0] code
);

  logic       tracks_scl_q, tracks_sda_q;
  logic       scl_lo_q, scl_hi_q, sda_lo_q, sda_hi_q;
  logic [1:0] code_q;
  pin_state_e verdict;

  always_ff @(posedge clk) begin
    if (rst || acc_clear) begin
      tracks_scl_q <= 1'b1;
      tracks_sda_q <= 1'b1;
      scl_lo_q     <= 1'b0;
      scl_hi_q     <= 1'b0;
      sda_lo_q     <= 1'b0;
      sda_hi_q     <= 1'b0;
    end else if (acc_sample) begin
      tracks_scl_q <= tracks_scl_q & (pin == scl);
      tracks_sda_q <= tracks_sda_q & (pin == sda);
      scl_lo_q     <= scl_lo_q | ~scl;
      scl_hi_q     <= scl_hi_q | scl;
      sda_lo_q     <= sda_lo_q | ~sda;
      sda_hi_q     <= sda_hi_q | sda;
    end
  end

  always_comb begin
    if (tracks_scl_q && scl_lo_q && scl_hi_q)
      verdict = PIN_SCL;
    else if (tracks_sda_q && sda_lo_q && sda_hi_q)
      verdict = PIN_SDA;
    else if (pin)
      verdict = PIN_VDD;
    else
      verdict = PIN_GND;
  end

  always_ff @(posedge clk) begin
    if (rst)
      code_q <= 2'b00;
    else if (latch_now)
      code_q <= verdict;
    else if (!decode_valid)
      code_q <= {1'b0, pin};
  end

  assign code = code_q;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (decode_valid && !latch_now) |=> $stable(code_q)); // R7

  AST_PROVISIONAL: assert property (@(posedge clk) disable iff (rst)
    (!decode_valid && !latch_now) |=> (code_q == {1'b0, $past(pin)})); // R2

endmodule

// File: rtl/apd_group_rom.sv
module apd_group_rom
  import apd_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_PINS-1:0] idx,
  output logic [2*NUM_PINS-1:0] grp_en
);

  localparam int unsigned IDX_W  = 2 * NUM_PINS;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned GROUPS = 2 * NUM_PINS;

  function automatic logic [GROUPS-1:0] build_entry(input logic [IDX_W-1:0] e);
    logic [GROUPS-1:0] r;
    r = '0;
    for (int p = 0; p < NUM_PINS; p++)
      r[2*p +: 2] = group_bits(pin_state_e'(e[2*p +: 2]));
    return r;
  endfunction

  logic [GROUPS-1:0] table_w [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign table_w[e] = build_entry(IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (rst)
      grp_en <= '0;
    else
      grp_en <= table_w[idx];
  end

endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder #(
  parameter int unsigned NUM_PINS   = 2,
  parameter int unsigned GROUP_SIZE = 4,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned ADDR_BASE  = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PINS-1:0]              addr_pin,
  input  logic                             sda,
  input  logic                             scl,
  input  logic                             bus_start,
  input  logic                             bus_stop,
  output logic [2*NUM_PINS-1:0]            pin_code,
  output logic                             decode_valid,
  output logic [ADDR_W-1:0]                slave_addr,
  output logic [2*NUM_PINS*GROUP_SIZE-1:0] pullup_en,
  output logic [2*NUM_PINS*GROUP_SIZE-1:0] default_lvl
);

  localparam int unsigned CODE_W = 2 * NUM_PINS;
  localparam int unsigned GROUPS = 2 * NUM_PINS;
  localparam int unsigned BASE_W = ADDR_W - CODE_W;

  logic acc_clear, acc_sample, latch_now, valid_w;
  logic [GROUPS-1:0] grp_en;

  apd_xfer_tracker u_tracker (
    .clk          (clk),
    .rst          (rst),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .acc_clear    (acc_clear),
    .acc_sample   (acc_sample),
    .latch_now    (latch_now),
    .decode_valid (valid_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    apd_pin_classifier u_cls (
      .clk          (clk),
      .rst          (rst),
      .pin          (addr_pin[p]),
      .sda          (sda),
      .scl          (scl),
      .acc_clear    (acc_clear),
      .acc_sample   (acc_sample),
      .latch_now    (latch_now),
      .decode_valid (valid_w),
      .code         (pin_code[2*p +: 2])
    );
  end

  apd_group_rom #(.NUM_PINS(NUM_PINS)) u_rom (
    .clk    (clk),
    .rst    (rst),
    .idx    (pin_code),
    .grp_en (grp_en)
  );

  // R11, R12: each group enable fans out to its ports, and the enabled ports default high.
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign pullup_en[g*GROUP_SIZE +: GROUP_SIZE]   = {GROUP_SIZE{grp_en[g]}};
    assign default_lvl[g*GROUP_SIZE +: GROUP_SIZE] = {GROUP_SIZE{grp_en[g]}};
  end

  assign decode_valid = valid_w;
  assign slave_addr   = {BASE_W'(ADDR_BASE), pin_code}; // R10

endmodule

// File: tb/addr_pin_decoder_tb.sv
`timescale 1ns/1ps
module addr_pin_decoder_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sda = 1'b1, scl = 1'b1;
  logic        bus_start = 1'b0, bus_stop = 1'b0;
  logic [1:0]  sel_a = 2'd0, sel_b = 2'd2;
  logic [1:0]  addr_pin;
  logic [3:0]  pin_code;
  logic        decode_valid;
  logic [6:0]  slave_addr;
  logic [15:0] pullup_en, default_lvl;

  int total = 0, bad = 0, cyc = 0;

  typedef struct {
    logic [3:0] codes;
    logic       vld;
    string      tag;
    int         due;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Pin wiring selection: 0 ground, 1 supply, 2 SCL, 3 SDA.
  function automatic logic src(input logic [1:0] s, input logic d, input logic c);
    case (s)
      2'd0: src = 1'b0;
      2'd1: src = 1'b1;
      2'd2: src = c;
      default: src = d;
    endcase
  endfunction

  assign addr_pin = {src(sel_b, sda, scl), src(sel_a, sda, scl)};

  addr_pin_decoder u_dut (
    .clk(clk), .rst(rst), .addr_pin(addr_pin), .sda(sda), .scl(scl),
    .bus_start(bus_start), .bus_stop(bus_stop), .pin_code(pin_code),
    .decode_valid(decode_valid), .slave_addr(slave_addr),
    .pullup_en(pullup_en), .default_lvl(default_lvl)
  );

  function automatic logic [15:0] exp_pu(input logic [3:0] c);
    logic [15:0] r;
    logic [1:0]  b;
    r = '0;
    for (int p = 0; p < 2; p++) begin
      case (c[2*p +: 2])
        2'b00: b = 2'b00;
        2'b01: b = 2'b11;
        2'b10: b = 2'b01;
        default: b = 2'b10;
      endcase
      for (int h = 0; h < 2; h++)
        if (b[h]) r[(2*p+h)*4 +: 4] = 4'hF;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [3:0] c, input logic v, input string tag);
    exp_t e;
    e.codes = c; e.vld = v; e.tag = tag; e.due = cyc + 1;
    q.push_back(e);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (q.size() != 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      check({e.tag, " code"}, 32'(pin_code), 32'(e.codes));
      check({e.tag, " R6 valid"}, 32'(decode_valid), 32'(e.vld));
      check({e.tag, " R10 addr"}, 32'(slave_addr), 32'({3'b101, e.codes}));
      check({e.tag, " R11 pullup"}, 32'(pullup_en), 32'(exp_pu(e.codes)));
      check({e.tag, " R12 default"}, 32'(default_lvl), 32'(exp_pu(e.codes)));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic xfer(input logic [7:0] data, input bit toggle);
    bus_start = 1'b1; tick(); bus_start = 1'b0;
    if (toggle)
      for (int i = 7; i >= 0; i--) begin
        scl = 1'b0; sda = data[i]; tick();
        scl = 1'b1; tick();
      end
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    sda = 1'b1; scl = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) tick();
    check("R1 reset code", 32'(pin_code), 0);
    check("R1 reset valid", 32'(decode_valid), 0);
    check("R1 reset pullup", 32'(pullup_en), 0);
    check("R1 reset default", 32'(default_lvl), 0);
    rst = 1'b0;
    repeat (3) tick();
    // pin0 ground, pin1 on idle-high SCL reads as static high
    push_exp(4'b01_00, 1'b0, "R2 provisional");
    repeat (3) tick();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    repeat (2) tick();
    push_exp(4'b01_00, 1'b0, "R8 stray stop before decode");
    repeat (3) tick();
    sel_a = 2'd2; sel_b = 2'd3;
    xfer(8'hA5, 1'b1);
    push_exp(4'b11_10, 1'b1, "R3 R4 R6 first decode");
    repeat (3) tick();
    sel_a = 2'd1; sel_b = 2'd0;
    repeat (3) tick();
    push_exp(4'b11_10, 1'b1, "R7 held after rewire");
    repeat (3) tick();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    repeat (2) tick();
    push_exp(4'b11_10, 1'b1, "R8 stray stop after decode");
    repeat (3) tick();
    xfer(8'h5A, 1'b1);
    push_exp(4'b00_01, 1'b1, "R5 R9 static levels");
    repeat (3) tick();
    sel_a = 2'd2; sel_b = 2'd3;
    xfer(8'h00, 1'b0);
    push_exp(4'b01_01, 1'b1, "R5 no toggles reads high");
    repeat (3) tick();
    sel_a = 2'd3; sel_b = 2'd2;
    xfer(8'h3C, 1'b1);
    push_exp(4'b10_11, 1'b1, "R3 R4 R9 swapped lines");
    repeat (3) tick();
    sel_a = 2'd0; sel_b = 2'd1;
    xfer(8'hC3, 1'b1);
    push_exp(4'b01_00, 1'b1, "R5 R9 ground and supply");
    wait (q.size() == 0);
    repeat (2) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule